// File: doc/BRIEF.md
# Special Bus Cycle Decoder

This block sits on the system side of a processor bus with 64-bit data and watches every address strobe. A strobe counts as a special cycle only when it arrives as a non-data, non-memory, write-direction cycle. Such cycles carry no memory or I/O transfer; they announce processor events. The block tells these events apart by the raw active-low byte-enable byte together with the upper address field. It raises a one-clock pulse for the event and returns the ready acknowledge that the processor waits for.

One byte-enable value gives different events depending on the address field. Another value starts a two-transfer trace message. In that message the low 32 data lanes carry valid data in both transfers, even though the byte enables mark those lanes as disabled. The first transfer holds the instruction pointer of a taken branch and the second holds the pointer of its target. The block captures both and presents them together as one pair with a valid pulse.

Top module: `special_cycle_decoder`

## Requirements
- R1: A strobe is decoded only when isData=0, isMemory=0 and isWrite=1 in the same clock. Any other combination gives no ready and no pulse.
- R2: With addrHi equal to zero, a special cycle decodes by byteEnN as follows: FEh gives eventPulse bit 0 (shutdown), FDh gives bit 1 (cache invalidate), F7h gives bit 2 (writeback and invalidate), and EFh gives bit 5 (flush acknowledge).
- R3: byteEnN FBh decodes as stop-grant (eventPulse bit 3) when addrHi equals 10h, and as halt (bit 4) when addrHi equals zero.
- R4: Every other byteEnN/addrHi pair in a special cycle raises eventPulse bit 6 (unknown special) and is still acknowledged.
- R5: For a single-transfer special cycle, readyOut is high for exactly the one clock after the strobe edge, and the event pulse appears in that same clock.
- R6: byteEnN DFh with addrHi zero starts a trace message. readyOut is high for two consecutive clocks after the strobe edge. dataLo is captured at the end of each of those clocks, whatever the byte enables say.
- R7: In the clock after the second transfer, traceValid pulses for one clock. traceSource then holds the first captured word and traceTarget holds the second.
- R8: At most one eventPulse bit is high in any clock, and each decoded event gives exactly one single-clock pulse.
- R9: Strobes that arrive while a trace message is in its transfers are ignored. They change neither ready, the pulses, nor the captured pair.
- R10: Synchronous reset clears readyOut, eventPulse, traceValid and any trace capture in progress. A trace message cut short by reset never produces traceValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addrStrobe | input | 1 | Address strobe, one clock per bus cycle |
| isData | input | 1 | Cycle type: 1 data, 0 code/special |
| isMemory | input | 1 | Cycle space: 1 memory, 0 I/O/special |
| isWrite | input | 1 | Direction: 1 write |
| byteEnN | input | 8 | Active-low byte enables, compared raw |
| addrHi | input | ADDR_W | Upper address field (bits 31 down to 3) |
| dataLo | input | DATA_W | Low data lanes |
| readyOut | output | 1 | Ready acknowledge to the processor |
| eventPulse | output | 7 | One-hot event pulses, bit map as in R2 to R4 |
| traceValid | output | 1 | Captured branch pair is valid this clock |
| traceSource | output | DATA_W | Branch instruction pointer |
| traceTarget | output | DATA_W | Branch target instruction pointer |

## Verification
The bench builds the block with ADDR_W = 29 and DATA_W = 32, so the address compare spans the full upper field. This lets the stimulus place near misses, such as 10h against zero or a lone set top bit, right beside the legal codes, and it exercises byte-enable values that are legal under one address and unknown under another. The full 32-bit capture width lets distinct source and target words show any swap or stale capture. Trace messages are driven with stray strobes inside their transfers and with a reset between the two transfers.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  localparam int BE_W  = 8;
  localparam int EVT_N = 7;

  // event bit positions on eventPulse
  localparam int EV_SHUTDOWN = 0;
  localparam int EV_INVAL    = 1;
  localparam int EV_WBINV    = 2;
  localparam int EV_STOPGNT  = 3;
  localparam int EV_HALT     = 4;
  localparam int EV_FLUSHACK = 5;
  localparam int EV_UNKNOWN  = 6;

  // raw active-low byte-enable codes
  localparam logic [BE_W-1:0] BE_SHUTDOWN = 8'hFE;
  localparam logic [BE_W-1:0] BE_INVAL    = 8'hFD;
  localparam logic [BE_W-1:0] BE_GNTHALT  = 8'hFB;
  localparam logic [BE_W-1:0] BE_WBINV    = 8'hF7;
  localparam logic [BE_W-1:0] BE_FLUSHACK = 8'hEF;
  localparam logic [BE_W-1:0] BE_TRACE    = 8'hDF;

  localparam int STOPGNT_ADDR = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER1 = 2'd1,
    ST_XFER2 = 2'd2
  } seqState_e;

  typedef struct packed {
    logic takeSource;
    logic takeTarget;
  } dpStrobe_t;

endpackage

// File: rtl/sbc_decode.sv
module sbc_decode
  import sbc_pkg::*;
#(
  parameter int ADDR_W = 29
) (
  input  logic [BE_W-1:0]   byteEnN,
  input  logic [ADDR_W-1:0] addrHi,
  output logic              decTrace,
  output logic [EVT_N-1:0]  decEvt
);

  localparam logic [ADDR_W-1:0] ADDR_ZERO = '0;
  localparam logic [ADDR_W-1:0] ADDR_GNT  = ADDR_W'(STOPGNT_ADDR);

  logic atZero;
  logic atGnt;

  assign atZero = (addrHi == ADDR_ZERO);
  assign atGnt  = (addrHi == ADDR_GNT);

  always_comb begin
    decEvt   = '0;
    decTrace = 1'b0;
    if (atZero && byteEnN == BE_SHUTDOWN)      decEvt[EV_SHUTDOWN] = 1'b1;
    else if (atZero && byteEnN == BE_INVAL)    decEvt[EV_INVAL]    = 1'b1;
    else if (atZero && byteEnN == BE_WBINV)    decEvt[EV_WBINV]    = 1'b1;
    else if (atGnt  && byteEnN == BE_GNTHALT)  decEvt[EV_STOPGNT]  = 1'b1;
    else if (atZero && byteEnN == BE_GNTHALT)  decEvt[EV_HALT]     = 1'b1;
    else if (atZero && byteEnN == BE_FLUSHACK) decEvt[EV_FLUSHACK] = 1'b1;
    else if (atZero && byteEnN == BE_TRACE)    decTrace            = 1'b1;
    else                                       decEvt[EV_UNKNOWN]  = 1'b1;
  end

  // R8
  always_comb begin
    dec_onehot_chk: assert ($countones({decTrace, decEvt}) == 1);
  end

endmodule

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
  import sbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             addrStrobe,
  input  logic             isData,
  input  logic             isMemory,
  input  logic             isWrite,
  input  logic             decTrace,
  input  logic [EVT_N-1:0] decEvt,
  output logic             readyOut,
  output logic [EVT_N-1:0] eventPulse,
  output dpStrobe_t        strb
);

  seqState_e state;
  logic      specialHit;

  assign specialHit = addrStrobe && !isData && !isMemory && isWrite;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      readyOut   <= 1'b0;
      eventPulse <= '0;
    end else begin
      readyOut   <= 1'b0;
      eventPulse <= '0;
      unique case (state)
        ST_IDLE: begin
          if (specialHit) begin
            readyOut <= 1'b1;
            if (decTrace) state <= ST_XFER1;
            else          eventPulse <= decEvt;
          end
        end
        ST_XFER1: begin
          readyOut <= 1'b1;
          state    <= ST_XFER2;
        end
        ST_XFER2: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.takeSource = (state == ST_XFER1);
    strb.takeTarget = (state == ST_XFER2);
  end

  // R8
  onehot_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(eventPulse));

  // R5
  pulse_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (|eventPulse) |-> readyOut);

  // R6
  xfer_order_chk: assert property (@(posedge clk) disable iff (rst)
    strb.takeSource |=> strb.takeTarget);

  // R6
  xfer_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.takeSource || strb.takeTarget) |-> readyOut);

  // R9
  xfer_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.takeSource || strb.takeTarget) |-> eventPulse == '0);

endmodule

// File: rtl/sbc_datapath.sv
module sbc_datapath
  import sbc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] dataLo,
  output logic              traceValid,
  output logic [DATA_W-1:0] traceSource,
  output logic [DATA_W-1:0] traceTarget
);

  always_ff @(posedge clk) begin
    if (rst) begin
      traceValid  <= 1'b0;
      traceSource <= '0;
      traceTarget <= '0;
    end else begin
      traceValid <= strb.takeTarget;
      if (strb.takeSource) traceSource <= dataLo;
      if (strb.takeTarget) traceTarget <= dataLo;
    end
  end

  // R7
  publish_chk: assert property (@(posedge clk) disable iff (rst)
    strb.takeTarget |=> traceValid && traceTarget == $past(dataLo));

  // R7
  single_valid_chk: assert property (@(posedge clk) disable iff (rst)
    traceValid |=> !traceValid);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !traceValid);

endmodule

// File: rtl/special_cycle_decoder.sv
module special_cycle_decoder
  import sbc_pkg::*;
#(
  parameter int ADDR_W = 29,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addrStrobe,
  input  logic              isData,
  input  logic              isMemory,
  input  logic              isWrite,
  input  logic [7:0]        byteEnN,
  input  logic [ADDR_W-1:0] addrHi,
  input  logic [DATA_W-1:0] dataLo,
  output logic              readyOut,
  output logic [6:0]        eventPulse,
  output logic              traceValid,
  output logic [DATA_W-1:0] traceSource,
  output logic [DATA_W-1:0] traceTarget
);

  logic             decTrace;
  logic [EVT_N-1:0] decEvt;
  dpStrobe_t        strb;

  sbc_decode #(.ADDR_W(ADDR_W)) u_decode (
    .byteEnN  (byteEnN),
    .addrHi   (addrHi),
    .decTrace (decTrace),
    .decEvt   (decEvt)
  );

  sbc_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .addrStrobe (addrStrobe),
    .isData     (isData),
    .isMemory   (isMemory),
    .isWrite    (isWrite),
    .decTrace   (decTrace),
    .decEvt     (decEvt),
    .readyOut   (readyOut),
    .eventPulse (eventPulse),
    .strb       (strb)
  );

  sbc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .dataLo      (dataLo),
    .traceValid  (traceValid),
    .traceSource (traceSource),
    .traceTarget (traceTarget)
  );

endmodule

// File: tb/sim_special_cycle_decoder.sv
`timescale 1ns/1ps
module sim_special_cycle_decoder;

  localparam int ADDR_W = 29;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic addrStrobe = 1'b0;
  logic isData = 1'b0, isMemory = 1'b0, isWrite = 1'b0;
  logic [7:0] byteEnN = 8'hFF;
  logic [ADDR_W-1:0] addrHi = '0;
  logic [DATA_W-1:0] dataLo = '0;
  logic readyOut, traceValid;
  logic [6:0] eventPulse;
  logic [DATA_W-1:0] traceSource, traceTarget;

  int checks = 0;
  int errors = 0;
  bit modelOn = 0;

  always #10 clk = ~clk;

  special_cycle_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst(rst), .addrStrobe(addrStrobe), .isData(isData),
    .isMemory(isMemory), .isWrite(isWrite), .byteEnN(byteEnN),
    .addrHi(addrHi), .dataLo(dataLo), .readyOut(readyOut),
    .eventPulse(eventPulse), .traceValid(traceValid),
    .traceSource(traceSource), .traceTarget(traceTarget)
  );

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mState = 0;
  bit mReady = 0, mValid = 0;
  bit [6:0] mEvt = '0;
  bit [DATA_W-1:0] mSrc = '0, mTgt = '0;

  function automatic int refCode(bit [7:0] be, bit [ADDR_W-1:0] a);
    if (a == 0) begin
      case (be)
        8'hFE: return 0;
        8'hFD: return 1;
        8'hF7: return 2;
        8'hFB: return 4;
        8'hEF: return 5;
        8'hDF: return 99;
        default: return 6;
      endcase
    end
    if (a == 16 && be == 8'hFB) return 3;
    return 6;
  endfunction

  always @(posedge clk) begin
    mReady = 0; mEvt = '0; mValid = 0;
    if (rst) begin
      mState = 0;
    end else begin
      case (mState)
        0: if (addrStrobe && !isData && !isMemory && isWrite) begin
             int c;
             c = refCode(byteEnN, addrHi);
             mReady = 1;
             if (c == 99) mState = 1;
             else mEvt[c] = 1'b1;
           end
        1: begin mSrc = dataLo; mReady = 1; mState = 2; end
        default: begin mTgt = dataLo; mValid = 1; mState = 0; end
      endcase
    end
  end

  always @(negedge clk) begin
    if (modelOn) begin
      check(readyOut == mReady, "R5 R6", "readyOut", 64'(readyOut), 64'(mReady));
      check(eventPulse == mEvt, "R2 R3 R4 R8", "eventPulse", 64'(eventPulse), 64'(mEvt));
      check(traceValid == mValid, "R7 R10", "traceValid", 64'(traceValid), 64'(mValid));
      if (mValid) begin
        check(traceSource == mSrc, "R6 R7", "traceSource", 64'(traceSource), 64'(mSrc));
        check(traceTarget == mTgt, "R6 R7", "traceTarget", 64'(traceTarget), 64'(mTgt));
      end
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      addrStrobe = 0;
    end
  endtask

  // one strobe; check ready/pulse in the clock after the strobe edge
  task automatic busCycle(bit dc, bit mio, bit wr, bit [7:0] be, bit [ADDR_W-1:0] a,
                          bit expRdy, bit [6:0] expEvt, string req);
    @(negedge clk);
    addrStrobe = 1; isData = dc; isMemory = mio; isWrite = wr; byteEnN = be; addrHi = a;
    @(negedge clk);
    addrStrobe = 0;
    check(readyOut == expRdy, req, "ready after strobe", 64'(readyOut), 64'(expRdy));
    check(eventPulse == expEvt, req, "event after strobe", 64'(eventPulse), 64'(expEvt));
    @(negedge clk);
    check(readyOut == 0 && eventPulse == 0, "R5 R8", "one-clock width",
          64'({readyOut, eventPulse}), 64'(0));
    idle(1);
  endtask

  task automatic traceMsg(bit [DATA_W-1:0] src, bit [DATA_W-1:0] tgt, bit noise);
    @(negedge clk);
    addrStrobe = 1; isData = 0; isMemory = 0; isWrite = 1; byteEnN = 8'hDF; addrHi = '0;
    @(negedge clk);
    addrStrobe = noise; byteEnN = 8'hFE; dataLo = src;
    check(readyOut == 1, "R6", "first transfer ready", 64'(readyOut), 64'(1));
    @(negedge clk);
    addrStrobe = noise; byteEnN = 8'hFB; dataLo = tgt;
    check(readyOut == 1, "R6", "second transfer ready", 64'(readyOut), 64'(1));
    @(negedge clk);
    addrStrobe = 0; dataLo = '0;
    check(traceValid == 1, "R7", "pair valid", 64'(traceValid), 64'(1));
    check(traceSource == src && traceTarget == tgt, "R7", "pair value",
          {traceSource, traceTarget}, {src, tgt});
    check(eventPulse == 0 && readyOut == 0, noise ? "R9" : "R6", "no extra activity",
          64'({readyOut, eventPulse}), 64'(0));
    idle(2);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    check(0, "watchdog", "run did not finish", 64'(0), 64'(1));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1;
    repeat (3) @(negedge clk);
    check(readyOut == 0 && eventPulse == 0 && traceValid == 0, "R10", "reset state",
          64'({readyOut, eventPulse, traceValid}), 64'(0));
    rst = 0;
    modelOn = 1;

    busCycle(0, 0, 1, 8'hFE, '0, 1, 7'b0000001, "R2");
    busCycle(0, 0, 1, 8'hFD, '0, 1, 7'b0000010, "R2");
    busCycle(0, 0, 1, 8'hF7, '0, 1, 7'b0000100, "R2");
    busCycle(0, 0, 1, 8'hEF, '0, 1, 7'b0100000, "R2");
    busCycle(0, 0, 1, 8'hFB, 29'h10, 1, 7'b0001000, "R3");
    busCycle(0, 0, 1, 8'hFB, '0, 1, 7'b0010000, "R3");
    busCycle(1, 0, 1, 8'hFE, '0, 0, 7'b0, "R1");
    busCycle(0, 1, 1, 8'hFE, '0, 0, 7'b0, "R1");
    busCycle(0, 0, 0, 8'hFE, '0, 0, 7'b0, "R1");
    busCycle(0, 0, 1, 8'hFB, 29'h20, 1, 7'b1000000, "R4");
    busCycle(0, 0, 1, 8'hDF, 29'h10, 1, 7'b1000000, "R4");
    busCycle(0, 0, 1, 8'hFE, 29'h10000000, 1, 7'b1000000, "R4");
    busCycle(0, 0, 1, 8'hFF, '0, 1, 7'b1000000, "R4");

    traceMsg(32'h0040_1000, 32'h0040_2F00, 0);
    traceMsg(32'hDEAD_BEEF, 32'h1234_5678, 1);

    // R10: reset between the two transfers
    @(negedge clk);
    addrStrobe = 1; isData = 0; isMemory = 0; isWrite = 1; byteEnN = 8'hDF; addrHi = '0;
    @(negedge clk);
    addrStrobe = 0; dataLo = 32'hAAAA_0001; rst = 1;
    @(negedge clk);
    rst = 0; dataLo = 32'hAAAA_0002;
    check(readyOut == 0, "R10", "ready cleared by reset", 64'(readyOut), 64'(0));
    repeat (3) begin
      @(negedge clk);
      check(traceValid == 0, "R10", "no pair after reset", 64'(traceValid), 64'(0));
    end

    // back-to-back strobes and random traffic against the model
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      addrStrobe = ($urandom_range(0, 2) != 0);
      isData   = ($urandom_range(0, 5) == 0);
      isMemory = ($urandom_range(0, 5) == 0);
      isWrite  = ($urandom_range(0, 5) != 0);
      case ($urandom_range(0, 7))
        0: byteEnN = 8'hFE; 1: byteEnN = 8'hFD; 2: byteEnN = 8'hFB;
        3: byteEnN = 8'hF7; 4: byteEnN = 8'hEF; 5, 6: byteEnN = 8'hDF;
        default: byteEnN = 8'($urandom);
      endcase
      case ($urandom_range(0, 3))
        0, 1: addrHi = '0;
        2: addrHi = 29'h10;
        default: addrHi = ADDR_W'($urandom);
      endcase
      dataLo = $urandom;
    end
    idle(4);
    modelOn = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule